// File: doc/BRIEF.md
# Serial Output Expander Chain Driver

This block keeps an array of on/off output states, eight per expander chip, for a chain of serial-in, parallel-out expanders wired in series. A host writes one bit at a time by index and asks for an update. When a bit has changed since the last transfer, the block shifts the whole array into the chain and then pulses the latch line. If nothing has changed, the update request is dropped.

Straight after reset the block runs a start-up pass on its own. It shifts a zero into every stage of the chain, latches those zeros, and only then raises an active-high enable. That enable drives an external inverter into the expanders' active-low output-enable pin, so the physical outputs never show stale data at power-up. Each half of the serial clock and the latch pulse lasts a parameterised number of system clocks.

Top module: `shiftchain_out_drv`

## Requirements
- R1: While reset is held, ser_data, ser_clk, ser_latch and out_en are all 0.
- R2: After reset the block makes CHIP_COUNT*8 serial clock pulses with ser_data 0, then one latch pulse. out_en rises on the cycle after that latch pulse ends and not before.
- R3: A bit write stores wr_val at index wr_idx (bit 0 is the first output of the chip nearest the driver). It marks the array as changed only if the stored value differs, so writing the value already held and then requesting an update produces no serial clock pulse.
- R4: An update request while no change is pending leaves busy low and produces no serial clock pulse.
- R5: An accepted update sends CHIP_COUNT*8 bits, highest index first and index 0 last. After latching, chain position p (counted from the driver) holds bit p. Each bit is set on ser_data while ser_clk is low and stays there until after the rising edge.
- R6: The low phase and the high phase of the serial clock each last exactly PHASE_CYCLES system clocks.
- R7: After the last bit, ser_clk returns low and ser_latch is high for PHASE_CYCLES clocks. Exactly one latch pulse is made per transfer.
- R8: busy is high for the whole start-up pass and for the whole of each transfer. Update requests made while busy are dropped and are not queued.
- R9: Bit writes made while busy still update the array and mark it changed. A later update then sends them.
- R10: Once out_en has risen it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bit write strobe |
| wr_idx | input | $clog2(CHIP_COUNT*8) | Index of the bit to write |
| wr_val | input | 1 | New value of the bit |
| upd_req | input | 1 | Request a transfer of the array to the chain |
| busy | output | 1 | Start-up pass or transfer in progress |
| ser_data | output | 1 | Serial data to the first chip |
| ser_clk | output | 1 | Serial shift clock |
| ser_latch | output | 1 | Storage latch strobe |
| out_en | output | 1 | Active-high output enable, inverted externally |

## Verification
An accepted request raises busy and shows the highest bit on ser_data one clock after the sampling edge. After that every phase changes exactly PHASE_CYCLES clocks later. A full transfer therefore takes 2*PHASE_CYCLES*CHIP_COUNT*8 + PHASE_CYCLES clocks, and out_en rises on the clock that ends the start-up latch phase. The bench steps a behavioural reference on every rising edge, using the inputs held since the previous edge. It compares all outputs on the following falling edge, so each result is checked in the exact cycle it is due. A model of the chain rebuilt from the serial lines checks the latched contents once busy falls.

// File: rtl/shiftchain_pkg.sv
package shiftchain_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LOW   = 2'd1,
      PH_HIGH  = 2'd2,
      PH_LATCH = 2'd3
   } phase_e;
endpackage

// File: rtl/shiftchain_tick.sv
module shiftchain_tick #(
   parameter int PHASE_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   if (PHASE_CYCLES < 1) begin : g_bad_div
      $error("PHASE_CYCLES must be at least 1");
   end

   if (PHASE_CYCLES == 1) begin : g_nodiv
      assign tick = run;
   end else begin : g_div
      localparam int CW = $clog2(PHASE_CYCLES);
      localparam logic [CW-1:0] LAST = CW'(PHASE_CYCLES - 1);
      logic [CW-1:0] cnt_q;

      assign tick = run && (cnt_q == LAST);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_q <= '0;
         else if (!run || tick) cnt_q <= '0;
         else                   cnt_q <= cnt_q + 1'b1;
      end

      // R6: two phase ends are never back to back when a phase spans several clocks
      a_r6_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick);
   end
endmodule

// File: rtl/shiftchain_store.sv
module shiftchain_store #(
   parameter int TOTAL = 16,
   parameter int IDXW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic            wr_val,
   input  logic            clr_dirty,
   input  logic [IDXW-1:0] rd_idx,
   output logic            rd_bit,
   output logic            dirty
);
   logic [TOTAL-1:0] bits_q;
   logic             wr_hit;
   logic             changed;

   assign wr_hit  = wr_en && (32'(wr_idx) < TOTAL);
   assign changed = wr_hit && (bits_q[wr_idx] != wr_val);
   assign rd_bit  = (32'(rd_idx) < TOTAL) ? bits_q[rd_idx] : 1'b0;

   for (genvar g = 0; g < TOTAL; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   bits_q[g] <= 1'b0;
         else if (wr_hit && (32'(wr_idx) == g))       bits_q[g] <= wr_val;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         dirty <= 1'b0;
      else if (changed)   dirty <= 1'b1;
      else if (clr_dirty) dirty <= 1'b0;
   end

   // R3: a write in range is visible in the array on the next cycle
   a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (bits_q[$past(wr_idx)] == $past(wr_val)));
   // R9: a change made in the same cycle as a transfer start stays pending
   a_r9_change_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (changed && clr_dirty) |=> dirty);
endmodule

// File: rtl/shiftchain_seq.sv
module shiftchain_seq
   import shiftchain_pkg::*;
#(
   parameter int TOTAL = 16,
   parameter int IDXW  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            upd_req,
   input  logic            dirty,
   input  logic            rd_bit,
   output logic [IDXW-1:0] rd_idx,
   output logic            clr_dirty,
   output logic            busy,
   output logic            ser_data,
   output logic            ser_clk,
   output logic            ser_latch,
   output logic            out_en
);
   localparam logic [IDXW-1:0] TOP_IDX = IDXW'(TOTAL - 1);

   phase_e          st_q;
   logic [IDXW-1:0] bit_q;
   logic            init_q;
   logic            data_q;
   logic            en_q;
   logic            start;

   assign start     = (st_q == PH_IDLE) && upd_req && dirty;
   assign clr_dirty = start;
   assign rd_idx    = (st_q == PH_IDLE) ? TOP_IDX : (bit_q - 1'b1);
   assign busy      = (st_q != PH_IDLE);
   assign ser_clk   = (st_q == PH_HIGH);
   assign ser_latch = (st_q == PH_LATCH);
   assign ser_data  = data_q;
   assign out_en    = en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= PH_LOW;
         bit_q  <= TOP_IDX;
         init_q <= 1'b1;
         data_q <= 1'b0;
         en_q   <= 1'b0;
      end else begin
         unique case (st_q)
            PH_IDLE: begin
               if (start) begin
                  st_q   <= PH_LOW;
                  bit_q  <= TOP_IDX;
                  data_q <= rd_bit;
               end
            end
            PH_LOW: begin
               if (tick) st_q <= PH_HIGH;
            end
            PH_HIGH: begin
               if (tick) begin
                  if (bit_q == '0) begin
                     st_q <= PH_LATCH;
                  end else begin
                     st_q   <= PH_LOW;
                     bit_q  <= bit_q - 1'b1;
                     data_q <= init_q ? 1'b0 : rd_bit;
                  end
               end
            end
            PH_LATCH: begin
               if (tick) begin
                  st_q   <= PH_IDLE;
                  data_q <= 1'b0;
                  if (init_q) begin
                     en_q   <= 1'b1;
                     init_q <= 1'b0;
                  end
               end
            end
            default: st_q <= PH_IDLE;
         endcase
      end
   end

   // R2: enable only ever rises right after a latch pulse
   a_r2_en_after_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_en) |-> $past(ser_latch));
   // R10: enable is sticky
   a_r10_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      out_en |=> out_en);
   // R7: latch opens only after the clock high phase of bit 0
   a_r7_latch_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_latch) |-> ($past(ser_clk) && (bit_q == '0)));
   // R5: an accepted transfer begins at the highest index
   a_r5_first_top: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (bit_q == TOP_IDX && st_q == PH_LOW));
endmodule

// File: rtl/shiftchain_out_drv.sv
module shiftchain_out_drv #(
   parameter int CHIP_COUNT   = 2,
   parameter int PHASE_CYCLES = 2,
   localparam int TOTAL = CHIP_COUNT * 8,
   localparam int IDXW  = $clog2(TOTAL)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [IDXW-1:0] wr_idx,
   input  logic            wr_val,
   input  logic            upd_req,
   output logic            busy,
   output logic            ser_data,
   output logic            ser_clk,
   output logic            ser_latch,
   output logic            out_en
);
   if (CHIP_COUNT < 1) begin : g_bad_chain
      $error("CHIP_COUNT must be at least 1");
   end

   logic            tick;
   logic            dirty;
   logic            clr_dirty;
   logic            rd_bit;
   logic [IDXW-1:0] rd_idx;

   shiftchain_tick #(.PHASE_CYCLES(PHASE_CYCLES)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   shiftchain_store #(.TOTAL(TOTAL), .IDXW(IDXW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_val   (wr_val),
      .clr_dirty(clr_dirty),
      .rd_idx   (rd_idx),
      .rd_bit   (rd_bit),
      .dirty    (dirty)
   );

   shiftchain_seq #(.TOTAL(TOTAL), .IDXW(IDXW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .upd_req  (upd_req),
      .dirty    (dirty),
      .rd_bit   (rd_bit),
      .rd_idx   (rd_idx),
      .clr_dirty(clr_dirty),
      .busy     (busy),
      .ser_data (ser_data),
      .ser_clk  (ser_clk),
      .ser_latch(ser_latch),
      .out_en   (out_en)
   );

   // R5: data holds steady while the serial clock is high
   a_r5_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
   // R4: with nothing pending an idle block stays idle
   a_r4_clean_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !dirty) |=> !busy);
endmodule

// File: tb/shiftchain_out_drv_bench.sv
module shiftchain_out_drv_bench;
   localparam int CHIPS = 2;
   localparam int DIV   = 3;
   localparam int TOTAL = CHIPS * 8;
   localparam int IDXW  = $clog2(TOTAL);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [IDXW-1:0] wr_idx = '0;
   logic wr_val = 1'b0;
   logic upd_req = 1'b0;
   logic busy, ser_data, ser_clk, ser_latch, out_en;

   int n_chk = 0;
   int n_fail = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   shiftchain_out_drv #(.CHIP_COUNT(CHIPS), .PHASE_CYCLES(DIV)) u_shiftchain_out_drv (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
      .upd_req(upd_req), .busy(busy), .ser_data(ser_data), .ser_clk(ser_clk),
      .ser_latch(ser_latch), .out_en(out_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // Chain model rebuilt from the serial lines: position 0 is nearest the driver
   logic [TOTAL-1:0] chain_sr = '0;
   logic [TOTAL-1:0] chain_out = '0;
   int clk_rises = 0;
   int latch_rises = 0;
   always @(posedge ser_clk) begin
      chain_sr <= {chain_sr[TOTAL-2:0], ser_data};
      clk_rises++;
   end
   always @(posedge ser_latch) begin
      chain_out <= chain_sr;
      latch_rises++;
   end

   // Behavioural reference, stepped on each rising edge
   int m_ph, m_cnt, m_bit;
   bit m_init, m_data, m_en, m_dirty;
   logic [TOTAL-1:0] m_arr;

   always @(posedge clk) begin
      logic [TOTAL-1:0] pre;
      bit clr;
      if (!rst_n) begin
         m_ph = 1; m_cnt = 0; m_bit = TOTAL - 1; m_init = 1;
         m_data = 0; m_en = 0; m_arr = '0; m_dirty = 0;
      end else begin
         pre = m_arr;
         clr = 0;
         if (m_ph == 0) begin
            if (upd_req && m_dirty) begin
               m_ph = 1; m_cnt = 0; m_bit = TOTAL - 1; m_data = pre[TOTAL-1]; clr = 1;
            end
         end else if (m_cnt == DIV - 1) begin
            m_cnt = 0;
            if (m_ph == 1) m_ph = 2;
            else if (m_ph == 2) begin
               if (m_bit == 0) m_ph = 3;
               else begin
                  m_ph = 1; m_bit--; m_data = m_init ? 1'b0 : pre[m_bit];
               end
            end else begin
               m_ph = 0; m_data = 0;
               if (m_init) begin m_en = 1; m_init = 0; end
            end
         end else m_cnt++;
         if (wr_en && pre[wr_idx] != wr_val) begin
            m_arr[wr_idx] = wr_val; m_dirty = 1;
         end else if (clr) m_dirty = 0;
      end
   end

   always @(negedge clk) begin
      if (!rst_n) begin
         chk(!ser_data && !ser_clk && !ser_latch && !out_en, "R1 outputs low in reset",
             {ser_data, ser_clk, ser_latch, out_en}, 0);
      end else begin
         chk(ser_data == m_data, "R5 ser_data per cycle", ser_data, m_data);
         chk(ser_clk == (m_ph == 2), "R6 ser_clk per cycle", ser_clk, m_ph == 2);
         chk(ser_latch == (m_ph == 3), "R7 ser_latch per cycle", ser_latch, m_ph == 3);
         chk(out_en == m_en, "R2 out_en per cycle", out_en, m_en);
         chk(busy == (m_ph != 0), "R8 busy per cycle", busy, m_ph != 0);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 200000);
         report();
      end
   end

   task automatic write_bit(input int idx, input bit val);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_idx = IDXW'(idx); wr_val = val;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic request();
      @(posedge clk); #1;
      upd_req = 1'b1;
      @(posedge clk); #1;
      upd_req = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      while (busy) @(negedge clk);
   endtask

   initial begin
      int c0, l0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R2: start-up pass
      wait_idle();
      chk(out_en == 1'b1, "R2 enable after start-up", out_en, 1);
      chk(clk_rises == TOTAL, "R2 start-up clock pulses", clk_rises, TOTAL);
      chk(latch_rises == 1, "R2 start-up latch pulses", latch_rises, 1);
      chk(chain_out == '0, "R2 chain cleared", int'(chain_out), 0);

      // R4: update with nothing pending
      c0 = clk_rises;
      request();
      repeat (10) @(negedge clk);
      chk(clk_rises == c0, "R4 no pulses when clean", clk_rises, c0);
      chk(busy == 1'b0, "R4 busy stays low", busy, 0);

      // R3: rewriting a held value leaves nothing pending
      write_bit(3, 1'b0);
      request();
      repeat (10) @(negedge clk);
      chk(clk_rises == c0, "R3 same value not pending", clk_rises, c0);

      // R5 / R7: pattern transfer; R8 / R9: activity while busy
      write_bit(0, 1'b1);
      write_bit(5, 1'b1);
      write_bit(9, 1'b1);
      c0 = clk_rises; l0 = latch_rises;
      request();
      repeat (10) @(posedge clk);
      write_bit(15, 1'b1);
      request();
      wait_idle();
      chk(chain_out == 16'h0221, "R5 chain order after transfer", int'(chain_out), 16'h0221);
      chk(clk_rises - c0 == TOTAL, "R5 bits per transfer", clk_rises - c0, TOTAL);
      chk(latch_rises - l0 == 1, "R7 one latch per transfer", latch_rises - l0, 1);
      c0 = clk_rises;
      repeat (8) @(negedge clk);
      chk(busy == 1'b0 && clk_rises == c0, "R8 busy request dropped", busy, 0);
      request();
      wait_idle();
      chk(chain_out == 16'h8221, "R9 write during busy sent later", int'(chain_out), 16'h8221);

      // R3: clearing bits
      write_bit(9, 1'b0);
      write_bit(0, 1'b0);
      request();
      wait_idle();
      chk(chain_out == 16'h8020, "R3 cleared bits sent", int'(chain_out), 16'h8020);
      chk(out_en == 1'b1, "R10 enable held", out_en, 1);
      repeat (4) @(negedge clk);
      report();
   end
endmodule